// File: doc/BRIEF.md
# Network Interrupt Status Collector

This block gathers interrupt requests from the ports of five network module bays and keeps them in two 16-bit status words. A bit that reads 0 means that a port is asking for service. A bit that reads 1 means that it is idle. The block combines every pending request into one level interrupt for the processor. After taking that interrupt, the processor reads the two words to find which bay and port raised it.

A request arrives as a bay number, a port number and one of two strobes. The raise strobe marks the port as pending. The drop strobe withdraws the request. Each bay has a fixed position in the status words. Bay 0 owns the whole of the first word. Bays 1 to 4 each own a 4-bit field in the second word. A bit is therefore found by adding the bay's base offset to the port number. The processor reads the words through a small address-decoded read port, and the words cannot be written from that port.

Top module: `netIrqCollector`

## Requirements
- R1: While reset is asserted and on the first cycle after it, both status words hold 0xFFFF and `irq` is 0.
- R2: A raise for bay 0 with port p (0 to 15) drives bit p of status word 0 to 0 at the clock edge where the strobe is sampled.
- R3: A raise for bay b in 1 to 4 with port p in 0 to 3 drives bit 4*(b-1)+p of status word 1 to 0. Bay 1 uses bits 3:0, bay 2 uses bits 7:4, bay 3 uses bits 11:8 and bay 4 uses bits 15:12.
- R4: A drop for a bay and port returns the mapped bit to 1. No other bit of either word changes.
- R5: `irq` is registered. One cycle after either word differs from 0xFFFF, `irq` is 1. One cycle after both words equal 0xFFFF, `irq` is 0.
- R6: Reading address 0x20 returns status word 0 and reading address 0x22 returns status word 1. Any other address returns 0x0000. The read is combinational on `rdAddr`.
- R7: A strobe with a bay number of 5 or more is ignored, and so is a strobe for bays 1 to 4 with a port of 4 or more. Neither word changes.
- R8: When raise and drop are strobed together, the raise wins and the mapped bit becomes 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| bay | input | 3 | Bay number of the request |
| port | input | 4 | Port number within the bay |
| raiseStb | input | 1 | Mark the port's request as pending (bit to 0) |
| dropStb | input | 1 | Withdraw the port's request (bit to 1) |
| rdAddr | input | 8 | Register read address |
| rdData | output | 16 | Read data for `rdAddr` |
| irq | output | 1 | Combined active-high interrupt, registered |

## Verification
The hardest case to reach from the ports is the instant when the status word has already changed but the registered interrupt still shows the old value. The driver checks `irq` just after the edge that takes each strobe, where it must still hold its previous level. It checks again one edge later, where the new level must appear. This matters most on the drop of the last outstanding request, when `irq` must fall only after both words return to all ones. Requests for bays 1 and 4 are kept pending at the same time to show that the two words and the per-bay fields do not disturb each other. Out-of-range strobes and a simultaneous raise and drop are then applied on top of that state.

// File: rtl/netIrqPkg.sv
package netIrqPkg;
  localparam int STATUS_W = 16;
  localparam int IDX_W    = $clog2(STATUS_W);
  localparam int NUM_WORDS = 2;

  // Strobes from the request decoder to the status datapath
  typedef struct packed {
    logic             upd;      // write one status bit this cycle
    logic             wordSel;  // 0: first word, 1: second word
    logic [IDX_W-1:0] bitIdx;   // bit inside the selected word
    logic             level;    // value written (0 = pending)
  } statusCmdT;
endpackage

// File: rtl/netIrqCtrl.sv
module netIrqCtrl
  import netIrqPkg::*;
#(
  parameter int NUM_BAYS = 5,
  parameter int BAY_W    = 3,
  parameter int PORT_W   = 4,
  parameter int FIELD_W  = 4
) (
  input  logic [BAY_W-1:0]  bay,
  input  logic [PORT_W-1:0] port,
  input  logic              raiseStb,
  input  logic              dropStb,
  output statusCmdT         cmd
);
  int baseOff;
  int portLim;
  int bitPos;
  logic inRange;

  always_comb begin
    if (int'(bay) == 0) begin
      baseOff = 0;
      portLim = STATUS_W;
    end else begin
      baseOff = (int'(bay) - 1) * FIELD_W;
      portLim = FIELD_W;
    end
    bitPos  = baseOff + int'(port);
    inRange = (int'(bay) < NUM_BAYS) && (int'(port) < portLim) && (bitPos < STATUS_W);

    cmd.upd     = (raiseStb || dropStb) && inRange;
    cmd.wordSel = (int'(bay) != 0);
    cmd.bitIdx  = IDX_W'(bitPos);
    cmd.level   = !raiseStb;   // raise has priority over drop
  end
endmodule

// File: rtl/netIrqDatapath.sv
module netIrqDatapath
  import netIrqPkg::*;
#(
  parameter int              ADDR_W  = 8,
  parameter logic [ADDR_W-1:0] W0_ADDR = 8'h20,
  parameter logic [ADDR_W-1:0] W1_ADDR = 8'h22
) (
  input  logic                clk,
  input  logic                rstN,
  input  statusCmdT           cmd,
  input  logic [ADDR_W-1:0]   rdAddr,
  output logic [STATUS_W-1:0] rdData,
  output logic [STATUS_W-1:0] word0,
  output logic [STATUS_W-1:0] word1,
  output logic                irq
);
  logic [NUM_WORDS-1:0][STATUS_W-1:0] words;
  logic [NUM_WORDS-1:0]               wordIdle;
  logic                               anyPending;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      words <= '1;
    end else if (cmd.upd) begin
      for (int w = 0; w < NUM_WORDS; w++) begin
        if (cmd.wordSel == 1'(w)) words[w][cmd.bitIdx] <= cmd.level;
      end
    end
  end

  for (genvar g = 0; g < NUM_WORDS; g++) begin : gIdle
    assign wordIdle[g] = &words[g];
  end

  assign anyPending = !(&wordIdle);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) irq <= 1'b0;
    else       irq <= anyPending;
  end

  always_comb begin
    if (rdAddr == W0_ADDR)      rdData = words[0];
    else if (rdAddr == W1_ADDR) rdData = words[1];
    else                        rdData = '0;
  end

  assign word0 = words[0];
  assign word1 = words[1];
endmodule

// File: rtl/netIrqCollector.sv
module netIrqCollector
  import netIrqPkg::*;
#(
  parameter int NUM_BAYS = 5,
  parameter int BAY_W    = 3,
  parameter int PORT_W   = 4,
  parameter int FIELD_W  = 4,
  parameter int ADDR_W   = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [BAY_W-1:0]    bay,
  input  logic [PORT_W-1:0]   port,
  input  logic                raiseStb,
  input  logic                dropStb,
  input  logic [ADDR_W-1:0]   rdAddr,
  output logic [STATUS_W-1:0] rdData,
  output logic                irq
);
  statusCmdT           cmd;
  logic [STATUS_W-1:0] word0;
  logic [STATUS_W-1:0] word1;

  netIrqCtrl #(
    .NUM_BAYS(NUM_BAYS), .BAY_W(BAY_W), .PORT_W(PORT_W), .FIELD_W(FIELD_W)
  ) uCtrl (
    .bay(bay), .port(port), .raiseStb(raiseStb), .dropStb(dropStb), .cmd(cmd)
  );

  netIrqDatapath #(
    .ADDR_W(ADDR_W), .W0_ADDR(ADDR_W'(8'h20)), .W1_ADDR(ADDR_W'(8'h22))
  ) uData (
    .clk(clk), .rstN(rstN), .cmd(cmd), .rdAddr(rdAddr), .rdData(rdData),
    .word0(word0), .word1(word1), .irq(irq)
  );
endmodule

// File: rtl/netIrqChecker.sv
module netIrqChecker
  import netIrqPkg::*;
#(
  parameter int NUM_BAYS = 5,
  parameter int BAY_W    = 3,
  parameter int PORT_W   = 4,
  parameter int FIELD_W  = 4,
  parameter int ADDR_W   = 8
) (
  input logic                clk,
  input logic                rstN,
  input logic [BAY_W-1:0]    bay,
  input logic [PORT_W-1:0]   port,
  input logic                raiseStb,
  input logic                dropStb,
  input logic [ADDR_W-1:0]   rdAddr,
  input logic [STATUS_W-1:0] rdData,
  input logic                irq,
  input logic [STATUS_W-1:0] word0,
  input logic [STATUS_W-1:0] word1
);
  logic badReq;
  assign badReq = (int'(bay) >= NUM_BAYS) || ((bay != '0) && (int'(port) >= FIELD_W));

  assert_reset_idle_R1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (irq == 1'b0 && word0 == '1 && word1 == '1));

  assert_bay0_raise_R2: assert property (@(posedge clk) disable iff (!rstN)
    (raiseStb && bay == '0) |=> (word0[$past(port)] == 1'b0));

  assert_bay0_drop_R4: assert property (@(posedge clk) disable iff (!rstN)
    (dropStb && !raiseStb && bay == '0) |=> (word0[$past(port)] == 1'b1));

  assert_irq_rise_R5: assert property (@(posedge clk) disable iff (!rstN)
    (word0 != '1 || word1 != '1) |=> irq);

  assert_irq_fall_R5: assert property (@(posedge clk) disable iff (!rstN)
    (word0 == '1 && word1 == '1) |=> !irq);

  assert_bad_req_ignored_R7: assert property (@(posedge clk) disable iff (!rstN)
    ((raiseStb || dropStb) && badReq) |=> ($stable(word0) && $stable(word1)));

  assert_raise_wins_R8: assert property (@(posedge clk) disable iff (!rstN)
    (raiseStb && dropStb && bay == '0) |=> (word0[$past(port)] == 1'b0));

  always_comb begin
    if (rstN && rdAddr == ADDR_W'(8'h20))
      assert_read_word0_R6: assert (rdData == word0);
    if (rstN && rdAddr == ADDR_W'(8'h22))
      assert_read_word1_R6: assert (rdData == word1);
  end
endmodule

bind netIrqCollector netIrqChecker #(
  .NUM_BAYS(NUM_BAYS), .BAY_W(BAY_W), .PORT_W(PORT_W), .FIELD_W(FIELD_W), .ADDR_W(ADDR_W)
) uChecker (
  .clk(clk), .rstN(rstN), .bay(bay), .port(port), .raiseStb(raiseStb),
  .dropStb(dropStb), .rdAddr(rdAddr), .rdData(rdData), .irq(irq),
  .word0(word0), .word1(word1)
);

// File: tb/netIrqCollector_test.sv
module netIrqCollector_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [2:0]  bay = '0;
  logic [3:0]  port = '0;
  logic        raiseStb = 1'b0;
  logic        dropStb = 1'b0;
  logic [7:0]  rdAddr = 8'h20;
  logic [15:0] rdData;
  logic        irq;

  netIrqCollector uut (
    .clk(clk), .rstN(rstN), .bay(bay), .port(port), .raiseStb(raiseStb),
    .dropStb(dropStb), .rdAddr(rdAddr), .rdData(rdData), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    logic [7:0]  addr;
    logic        isIrq;
    logic [15:0] expVal;
    string       tag;
  } expItemT;

  expItemT     expQ[$];
  int          nCompared = 0;
  int          nMismatch = 0;
  logic        monBusy = 1'b0;
  logic        summaryDone = 1'b0;
  logic [15:0] model0 = 16'hFFFF;
  logic [15:0] model1 = 16'hFFFF;

  task automatic checkVal(input string tag, input logic [15:0] act, input logic [15:0] exp);
    nCompared++;
    if (act !== exp) begin
      nMismatch++;
      $display("FAIL %s: actual 0x%04h expected 0x%04h", tag, act, exp);
    end
  endtask

  // Monitor: pops expected items and compares them with the outputs
  initial begin
    forever begin
      @(negedge clk);
      if (expQ.size() > 0) begin
        expItemT it;
        monBusy = 1'b1;
        it = expQ.pop_front();
        rdAddr = it.addr;
        #1;
        if (it.isIrq) checkVal(it.tag, {15'b0, irq}, it.expVal);
        else          checkVal(it.tag, rdData, it.expVal);
        monBusy = 1'b0;
      end
    end
  end

  function automatic logic modelIrq();
    return (model0 != 16'hFFFF) || (model1 != 16'hFFFF);
  endfunction

  task automatic pushRead(input logic [7:0] a, input logic [15:0] e, input string tag);
    expItemT it;
    it.addr = a; it.isIrq = 1'b0; it.expVal = e; it.tag = tag;
    expQ.push_back(it);
  endtask

  task automatic pushAll(input string tag);
    expItemT it;
    pushRead(8'h20, model0, tag);
    pushRead(8'h22, model1, tag);
    it.addr = 8'h20; it.isIrq = 1'b1; it.expVal = {15'b0, modelIrq()}; it.tag = tag;
    expQ.push_back(it);
    wait (expQ.size() == 0 && !monBusy);
  endtask

  // Requirement model: bay 0 -> word 0 bit p; bays 1..4 -> word 1 bit 4*(b-1)+p, p<4
  task automatic modelApply(input int b, input int p, input logic r, input logic d);
    logic lvl;
    if (!(r || d)) return;
    lvl = r ? 1'b0 : 1'b1;
    if (b == 0 && p < 16)                    model0[p] = lvl;
    else if (b >= 1 && b <= 4 && p < 4)      model1[4*(b-1)+p] = lvl;
  endtask

  // Driver: one strobe cycle, registered irq timing check, then scoreboard items
  task automatic doReq(input int b, input int p, input logic r, input logic d, input string tag);
    logic prevIrq;
    prevIrq = modelIrq();
    @(negedge clk);
    bay = 3'(b); port = 4'(p); raiseStb = r; dropStb = d;
    @(posedge clk); #1;
    checkVal({tag, " R5 irq lags status by one cycle"}, {15'b0, irq}, {15'b0, prevIrq});
    @(negedge clk);
    raiseStb = 1'b0; dropStb = 1'b0;
    modelApply(b, p, r, d);
    @(posedge clk); #1;
    pushAll(tag);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    checkVal("R1 reset word0", (uut.rdData === 16'hFFFF && rdAddr == 8'h20) ? 16'hFFFF : rdData, 16'hFFFF);
    checkVal("R1 reset irq", {15'b0, irq}, 16'h0000);
    @(negedge clk);
    rstN = 1'b1;
    @(posedge clk); #1;
    pushAll("R1 after reset");

    doReq(0, 0,  1'b1, 1'b0, "R2 bay0 port0");
    doReq(0, 15, 1'b1, 1'b0, "R2 bay0 port15");
    doReq(1, 0,  1'b1, 1'b0, "R3 bay1 port0");
    doReq(2, 3,  1'b1, 1'b0, "R3 bay2 port3");
    doReq(3, 1,  1'b1, 1'b0, "R3 bay3 port1");
    doReq(4, 3,  1'b1, 1'b0, "R3 bay4 port3");

    doReq(5, 0,  1'b1, 1'b0, "R7 bay5 ignored");
    doReq(7, 2,  1'b0, 1'b1, "R7 bay7 ignored");
    doReq(2, 4,  1'b1, 1'b0, "R7 bay2 port4 ignored");
    doReq(4, 9,  1'b0, 1'b1, "R7 bay4 port9 ignored");

    doReq(3, 2,  1'b1, 1'b1, "R8 raise beats drop");
    doReq(0, 7,  1'b1, 1'b1, "R8 raise beats drop bay0");

    pushRead(8'h24, 16'h0000, "R6 unmapped 0x24");
    pushRead(8'h21, 16'h0000, "R6 unmapped 0x21");
    wait (expQ.size() == 0 && !monBusy);

    doReq(0, 0,  1'b0, 1'b1, "R4 drop bay0 port0");
    doReq(0, 15, 1'b0, 1'b1, "R4 drop bay0 port15");
    doReq(0, 7,  1'b0, 1'b1, "R4 drop bay0 port7");
    doReq(2, 3,  1'b0, 1'b1, "R4 drop bay2 port3");
    doReq(3, 1,  1'b0, 1'b1, "R4 drop bay3 port1");
    doReq(3, 2,  1'b0, 1'b1, "R4 drop bay3 port2");
    doReq(4, 3,  1'b0, 1'b1, "R4 drop bay4 port3");
    doReq(1, 0,  1'b0, 1'b1, "R5 last drop clears irq");

    if (!summaryDone) begin
      summaryDone = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCompared, nMismatch);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!summaryDone) begin
      summaryDone = 1'b1;
      nCompared++;
      nMismatch++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCompared, nMismatch);
      $finish;
    end
  end
endmodule